// File: doc/BRIEF.md
# Gatable Astable and Retriggerable One-Shot Timer

This block is a clocked replacement for a resistor-capacitor multivibrator. The analog time base becomes a down-counter that measures three programmable cycle counts. `T1_CYC` and `T2_CYC` are the high and low segments of the internal oscillator. `T1S_CYC` is a longer first high segment that follows every start. A divide-by-two stage is folded into the controller and produces the main output `q_o` and its complement `q_n_o`. The oscillator itself appears on `osc_o`.

The block has two uses. In the first, a level on either gate input starts a free-running square wave, and removing the gate stops it. In the second, edges on the trigger inputs fire a single pulse. The pulse has a fixed width and lasts whole oscillator periods. A separate retrigger input lengthens it period by period. An external reset input clears any activity and holds the block idle.

Every asynchronous input passes through a two-flop synchronizer before any edge is detected. A new input therefore reaches the output on the third rising clock edge. All pins are plain levels; no data stream passes through the block.

Top module: `rc_multivib`

## Requirements
- R1: While `rst_n` is low and after it is released with no input active, `q_o` is 0, `q_n_o` is 1 and `osc_o` is 0.
- R2: `q_n_o` is the exact complement of `q_o` in every cycle.
- R3: A rising edge on `trig_pos_i` while `trig_neg_i` is low sets `q_o` high on the third rising clock edge after the change. `q_o` then stays high for exactly `T1S_CYC + T2_CYC` cycles, however long the trigger is held. A rising edge on `trig_pos_i` while `trig_neg_i` is high starts nothing.
- R4: A falling edge on `trig_neg_i` while `trig_pos_i` is high starts the same pulse as R3.
- R5: Edges on `trig_pos_i` or `trig_neg_i` during a pulse do not change its width.
- R6: From idle, a single short rising pulse on `retrig_i` gives a pulse of `T1S_CYC + T2_CYC` cycles. A second rising edge inside the first period gives `T1S_CYC + T1_CYC + 2*T2_CYC` cycles.
- R7: If `retrig_i` is still high at the end of a period, the pulse is extended by one more period of `T1_CYC + T2_CYC` cycles. `q_o` falls at the first period end at which `retrig_i` is low.
- R8: With `gate_en_i` high, `q_o` toggles continuously. Its first high half lasts `T1S_CYC + T2_CYC` cycles and every later half lasts `T1_CYC + T2_CYC` cycles.
- R9: `gate_en_n_i` low alone starts the same free-running output as R8.
- R10: While running, `osc_o` is high for `T1_CYC` cycles and then low for `T2_CYC` cycles, so one half of the `q_o` period equals one `osc_o` period. `q_o` only rises while `osc_o` is high. `osc_o` is low whenever the block is idle.
- R11: When both gates are removed, `q_o` and `osc_o` go low by the third clock edge and stay low.
- R12: `ext_rst_i` high ends any pulse, with `q_o` low by the third clock edge. While it stays high, no trigger starts a pulse. It overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| trig_pos_i | input | 1 | Rising-edge trigger |
| trig_neg_i | input | 1 | Falling-edge trigger |
| gate_en_i | input | 1 | Active-high free-running enable |
| gate_en_n_i | input | 1 | Active-low free-running enable |
| retrig_i | input | 1 | Retrigger, extends the pulse while high |
| ext_rst_i | input | 1 | External clear, active high |
| q_o | output | 1 | Main output |
| q_n_o | output | 1 | Complement of `q_o` |
| osc_o | output | 1 | Internal oscillator |

## Verification
The hardest condition to reach is a pulse extension that depends on where a retrigger level sits relative to a period boundary. The bench holds `retrig_i` for a fixed number of cycles and works out which period ends fall inside that window. It then compares the resulting whole-period width. Hold times are chosen so that no period end falls near the release of the retrigger. Stimulus and measurement run in parallel branches, so that a second retrigger edge, or a trigger edge, arrives while a pulse that is already being measured is still running.

// File: rtl/mv_pkg.sv
package mv_pkg;
  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_ONE  = 2'd1,
    MV_AST  = 2'd2
  } mv_mode_e;

  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } mv_phase_e;

  // input bit positions inside the synchronizer vector
  localparam int unsigned IN_POS  = 0;
  localparam int unsigned IN_NEG  = 1;
  localparam int unsigned IN_EN   = 2;
  localparam int unsigned IN_EN_N = 3;
  localparam int unsigned IN_RET  = 4;
  localparam int unsigned IN_RST  = 5;
  localparam int unsigned IN_W    = 6;
endpackage

// File: rtl/mv_sync.sv
module mv_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/mv_phase_timer.sv
module mv_phase_timer
  import mv_pkg::*;
#(
  parameter int unsigned T1_CYC  = 11,
  parameter int unsigned T2_CYC  = 11,
  parameter int unsigned T1S_CYC = 14,
  parameter int unsigned CNT_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic halt_i,
  input  logic keep_i,
  output logic osc_o,
  output logic period_end_o
);
  logic             active_q;
  mv_phase_e        phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign period_end_o = active_q && (phase_q == PH_LO) && (cnt_q == '0);
  assign osc_o        = active_q && (phase_q == PH_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_HI;
      cnt_q    <= '0;
    end else if (halt_i) begin
      active_q <= 1'b0;
      phase_q  <= PH_HI;
      cnt_q    <= '0;
    end else if (launch_i) begin
      active_q <= 1'b1;
      phase_q  <= PH_HI;
      cnt_q    <= CNT_W'(T1S_CYC - 1);
    end else if (active_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (phase_q == PH_HI) begin
        phase_q <= PH_LO;
        cnt_q   <= CNT_W'(T2_CYC - 1);
      end else if (keep_i) begin
        phase_q <= PH_HI;
        cnt_q   <= CNT_W'(T1_CYC - 1);
      end else begin
        active_q <= 1'b0;
        phase_q  <= PH_HI;
      end
    end
  end
endmodule

// File: rtl/mv_ctrl.sv
module mv_ctrl
  import mv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pos_i,
  input  logic     neg_i,
  input  logic     gate_i,
  input  logic     ret_i,
  input  logic     clr_i,
  input  logic     period_end_i,
  output logic     launch_o,
  output logic     halt_o,
  output logic     keep_o,
  output mv_mode_e mode_o,
  output logic     q_o
);
  mv_mode_e mode_q, mode_d;
  logic     q_q, q_d;
  logic     pend_q, pend_d;
  logic     pos_p, neg_p, ret_p;
  logic     pos_rise, neg_fall, ret_rise, fire;

  assign pos_rise = pos_i & ~pos_p;
  assign neg_fall = ~neg_i & neg_p;
  assign ret_rise = ret_i & ~ret_p;
  assign fire     = (pos_rise & ~neg_i) | (neg_fall & pos_i) | ret_rise;
  assign keep_o   = (mode_q == MV_AST) | pend_q | ret_rise | ret_i;

  always_comb begin
    mode_d   = mode_q;
    q_d      = q_q;
    pend_d   = pend_q;
    launch_o = 1'b0;
    halt_o   = 1'b0;
    if (clr_i) begin
      mode_d = MV_IDLE;
      q_d    = 1'b0;
      pend_d = 1'b0;
      halt_o = 1'b1;
    end else begin
      unique case (mode_q)
        MV_IDLE: begin
          if (gate_i) begin
            mode_d   = MV_AST;
            q_d      = 1'b1;
            launch_o = 1'b1;
          end else if (fire) begin
            mode_d   = MV_ONE;
            q_d      = 1'b1;
            pend_d   = 1'b0;
            launch_o = 1'b1;
          end
        end
        MV_ONE: begin
          pend_d = pend_q | ret_rise;
          if (period_end_i) begin
            pend_d = 1'b0;
            if (!keep_o) begin
              mode_d = MV_IDLE;
              q_d    = 1'b0;
            end
          end
        end
        MV_AST: begin
          if (!gate_i) begin
            mode_d = MV_IDLE;
            q_d    = 1'b0;
            halt_o = 1'b1;
          end else if (period_end_i) begin
            q_d = ~q_q;
          end
        end
        default: begin
          mode_d = MV_IDLE;
          q_d    = 1'b0;
          halt_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MV_IDLE;
      q_q    <= 1'b0;
      pend_q <= 1'b0;
      pos_p  <= 1'b0;
      neg_p  <= 1'b0;
      ret_p  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      q_q    <= q_d;
      pend_q <= pend_d;
      pos_p  <= pos_i;
      neg_p  <= neg_i;
      ret_p  <= ret_i;
    end
  end

  assign mode_o = mode_q;
  assign q_o    = q_q;
endmodule

// File: rtl/rc_multivib.sv
module rc_multivib
  import mv_pkg::*;
#(
  parameter int unsigned T1_CYC  = 11,
  parameter int unsigned T2_CYC  = 11,
  parameter int unsigned T1S_CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_pos_i,
  input  logic trig_neg_i,
  input  logic gate_en_i,
  input  logic gate_en_n_i,
  input  logic retrig_i,
  input  logic ext_rst_i,
  output logic q_o,
  output logic q_n_o,
  output logic osc_o
);
  localparam int unsigned MAX12 = (T1_CYC > T2_CYC) ? T1_CYC : T2_CYC;
  localparam int unsigned MAXT  = (T1S_CYC > MAX12) ? T1S_CYC : MAX12;
  localparam int unsigned CNT_W = $clog2(MAXT + 1);
  localparam logic [IN_W-1:0] SYNC_RST = IN_W'(1) << IN_EN_N;

  logic [IN_W-1:0] raw, syn;
  logic            rst_s, gate_s;
  logic            launch, halt, keep, period_end;
  mv_mode_e        mode_q;

  assign raw[IN_POS]  = trig_pos_i;
  assign raw[IN_NEG]  = trig_neg_i;
  assign raw[IN_EN]   = gate_en_i;
  assign raw[IN_EN_N] = gate_en_n_i;
  assign raw[IN_RET]  = retrig_i;
  assign raw[IN_RST]  = ext_rst_i;

  mv_sync #(.W(IN_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign rst_s  = syn[IN_RST];
  assign gate_s = syn[IN_EN] | ~syn[IN_EN_N];

  mv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pos_i(syn[IN_POS]), .neg_i(syn[IN_NEG]), .gate_i(gate_s),
    .ret_i(syn[IN_RET]), .clr_i(rst_s), .period_end_i(period_end),
    .launch_o(launch), .halt_o(halt), .keep_o(keep),
    .mode_o(mode_q), .q_o(q_o)
  );

  mv_phase_timer #(
    .T1_CYC(T1_CYC), .T2_CYC(T2_CYC), .T1S_CYC(T1S_CYC), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .halt_i(halt),
    .keep_i(keep), .osc_o(osc_o), .period_end_o(period_end)
  );

  assign q_n_o = ~q_o;
endmodule

// File: rtl/mv_checker.sv
module mv_checker
  import mv_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     rst_s,
  input logic     gate_s,
  input mv_mode_e mode_q,
  input logic     q,
  input logic     osc
);
  assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_s |=> (!q && !osc));

  assert_gate_off_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MV_AST && !gate_s) |=> !q);

  assert_rise_in_high_seg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> osc);

  assert_idle_osc_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MV_IDLE) |-> !osc);

  assert_oneshot_holds_q_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MV_ONE) |-> q);
endmodule

bind rc_multivib mv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rst_s(rst_s), .gate_s(gate_s),
  .mode_q(mode_q), .q(q_o), .osc(osc_o)
);

// File: tb/rc_multivib_tb.sv
module rc_multivib_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T1 = 11, T2 = 11, T1S = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pos = 0, neg = 0, en = 0, en_n = 1, ret = 0, xr = 0;
  logic q, qn, osc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_multivib #(.T1_CYC(T1), .T2_CYC(T2), .T1S_CYC(T1S)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_pos_i(pos), .trig_neg_i(neg),
    .gate_en_i(en), .gate_en_n_i(en_n), .retrig_i(ret), .ext_rst_i(xr),
    .q_o(q), .q_n_o(qn), .osc_o(osc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rise(output int lat);
    lat = 0;
    while (q !== 1'b1 && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic wait_val(input logic v, output int lat);
    lat = 0;
    while (q !== v && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic run_len(input logic v, output int w);
    w = 0;
    while (q === v && w < 1000) begin @(negedge clk); w++; end
  endtask

  task automatic stays_low(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (q !== 1'b0 || osc !== 1'b0) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    cyc(3);
    check(q === 1'b0 && qn === 1'b1 && osc === 1'b0, "R1 in reset", q, 0);
    rst_n = 1'b1;
    stays_low(20, "R1 after release");
    check(qn === ~q, "R2 idle", qn, 1);
  endtask

  task automatic t_pos_trigger;
    int lat, w;
    @(negedge clk); pos = 1;
    @(negedge clk); pos = 0;
    wait_rise(lat);
    check(lat == 2, "R3 latency", lat + 1, 3);
    check(qn === 1'b0, "R2 during pulse", qn, 0);
    run_len(1'b1, w);
    check(w == T1S + T2, "R3 short trigger width", w, T1S + T2);
    cyc(5);
    @(negedge clk); pos = 1;
    wait_rise(lat);
    run_len(1'b1, w);
    check(w == T1S + T2, "R3 long trigger width", w, T1S + T2);
    cyc(30); pos = 0; cyc(5);
    check(q === 1'b0, "R3 no restart on held trigger", q, 0);
    neg = 1; cyc(4);
    pos = 1;
    stays_low(15, "R3 rising edge with neg high ignored");
  endtask

  task automatic t_neg_trigger;
    int lat, w;
    neg = 0;
    wait_rise(lat);
    check(lat <= 4, "R4 neg falling starts pulse", lat, 3);
    run_len(1'b1, w);
    check(w == T1S + T2, "R4 width", w, T1S + T2);
    pos = 0; cyc(10);
  endtask

  task automatic t_trig_during_pulse;
    int lat, w;
    fork
      begin
        @(negedge clk); pos = 1; cyc(2); pos = 0;
        cyc(8); pos = 1; cyc(2); pos = 0;
        cyc(2); neg = 1; cyc(2); pos = 1; cyc(1); neg = 0; cyc(1); pos = 0;
      end
      begin wait_rise(lat); run_len(1'b1, w); end
    join
    check(w == T1S + T2, "R5 width unchanged", w, T1S + T2);
    cyc(10);
  endtask

  task automatic t_retrig_pulses;
    int lat, w;
    @(negedge clk); ret = 1; cyc(2); ret = 0;
    wait_rise(lat); run_len(1'b1, w);
    check(w == T1S + T2, "R6 single retrigger", w, T1S + T2);
    cyc(5);
    fork
      begin @(negedge clk); ret = 1; cyc(3); ret = 0; cyc(6); ret = 1; cyc(3); ret = 0; end
      begin wait_rise(lat); run_len(1'b1, w); end
    join
    check(w == T1S + T1 + 2*T2, "R6 two retriggers", w, T1S + T1 + 2*T2);
    cyc(5);
  endtask

  task automatic t_retrig_hold(input int hold);
    int lat, w, exp_w, e;
    exp_w = T1S + T2; e = exp_w;
    while (e <= hold - 1) begin exp_w += T1 + T2; e += T1 + T2; end
    fork
      begin @(negedge clk); ret = 1; cyc(hold); ret = 0; end
      begin wait_rise(lat); run_len(1'b1, w); end
    join
    check(w == exp_w, "R7 held retrigger width", w, exp_w);
    cyc(5);
  endtask

  task automatic t_astable(input bit use_n);
    int lat, w;
    @(negedge clk);
    if (use_n) en_n = 0; else en = 1;
    wait_rise(lat);
    check(lat <= 4, use_n ? "R9 start latency" : "R8 start latency", lat, 3);
    run_len(1'b1, w);
    check(w == T1S + T2, use_n ? "R9 first half" : "R8 first half", w, T1S + T2);
    run_len(1'b0, w);
    check(w == T1 + T2, use_n ? "R9 low half" : "R8 low half", w, T1 + T2);
    run_len(1'b1, w);
    check(w == T1 + T2, use_n ? "R9 later high half" : "R8 later high half", w, T1 + T2);
    if (!use_n) begin
      int hi = 0, lo = 0;
      while (osc !== 1'b1) @(negedge clk);
      while (osc === 1'b1 && hi < 100) begin @(negedge clk); hi++; end
      while (osc === 1'b0 && lo < 100) begin @(negedge clk); lo++; end
      check(hi == T1, "R10 osc high segment", hi, T1);
      check(lo == T2, "R10 osc low segment", lo, T2);
      check(qn === ~q, "R2 astable", qn, ~q);
    end
    wait_val(1'b1, lat); cyc(4);
    if (use_n) en_n = 1; else en = 0;
    wait_val(1'b0, lat);
    check(lat <= 3, "R11 gate removal latency", lat, 3);
    stays_low(60, "R11 stays low");
  endtask

  task automatic t_ext_reset;
    int lat, w;
    @(negedge clk); pos = 1; cyc(1); pos = 0;
    wait_rise(lat); cyc(8);
    xr = 1;
    wait_val(1'b0, lat);
    check(lat <= 3, "R12 clear latency", lat, 3);
    cyc(3); pos = 1; cyc(2); pos = 0; ret = 1; cyc(2); ret = 0; en = 1;
    stays_low(30, "R12 blocks triggers and gate");
    en = 0; cyc(5); xr = 0; cyc(5);
    stays_low(10, "R12 idle after release");
  endtask

  initial begin
    t_reset();
    t_pos_trigger();
    t_neg_trigger();
    t_trig_during_pulse();
    t_retrig_pulses();
    t_retrig_hold(60);
    t_retrig_hold(10);
    t_astable(1'b0);
    t_astable(1'b1);
    t_ext_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule